// File: doc/BRIEF.md
# Systolic Multiply-Accumulate Chain with Partial-Sum Recirculation

This block evaluates one neural-network layer as a matrix–vector product on a one-dimensional systolic chain. Every processing element keeps a single input activation in a register and a private bank of weights. An issued token enters at the head of the chain and carries a wide partial sum, a weight address and a lane count. At each stage the element multiplies its activation by the addressed weight and adds the product to the sum arriving from upstream. The sum that leaves the last element goes to an activation stage outside this block.

A layer can have more inputs than the chain has elements. Such a layer is split into passes. A pass can send its tail sums into an internal accumulator FIFO instead of the output. The next pass takes them back at the head of the chain, in the same order. Between passes the surrounding sequencer reloads the activation registers. Activations and weights are signed 16-bit values with 7 fractional bits. Sums are 48 bits wide and carry 14 fractional bits.

Top module: `mac_chain`

## Requirements
- R1: After reset `sumValid` is low and every activation register holds 0, so an issue made before any activation load yields a sum equal to its head value.
- R2: Each contributing element adds the signed 32-bit product of its activation and the weight at the token's address, sign-extended to 48 bits, to the incoming sum.
- R3: A token whose issue is sampled at clock edge E appears at `sumOut` after edge E+NUM_PE-1, which is the NUM_PE-th edge counting E. Tokens may be issued on consecutive cycles and leave one per cycle, in issue order.
- R4: Element i (element 0 is the head) contributes only when i < `issueLanes`. Every other element passes the sum through unchanged, so `issueLanes` = 0 returns the head value.
- R5: With `srcAcc` = 0 the head sum is zero. With `srcAcc` = 1 the head sum is the oldest accumulator FIFO entry, and that entry is removed.
- R6: A token issued with `dstAcc` = 1 never raises `sumValid`. Its final sum is appended to the accumulator FIFO, and later passes read these entries back in first-in, first-out order. A FIFO entry written at one edge can be taken by an issue sampled at the following edge.
- R7: A cycle without `issue` creates no output beat, leaves the partial sums that are still in flight unchanged and does not touch the FIFO.
- R8: A weight write (`wgtWrEn`) updates only the entry `wgtWrAddr` of element `wgtWrPe`.
- R9: An activation load (`actLoad`) replaces only the activation of element `actPe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wgtWrEn | input | 1 | Weight write strobe |
| wgtWrPe | input | PE_W | Element selected by the weight write |
| wgtWrAddr | input | ADDR_W | Weight entry address |
| wgtWrData | input | DATA_W | Weight value, signed Q8.7 |
| actLoad | input | 1 | Activation load strobe |
| actPe | input | PE_W | Element selected by the activation load |
| actData | input | DATA_W | Activation value, signed Q8.7 |
| issue | input | 1 | Inject one token at the head |
| issueAddr | input | ADDR_W | Weight address used by every element for this token |
| issueLanes | input | LANE_W | Number of contributing elements, 0 to NUM_PE |
| srcAcc | input | 1 | Head sum from the accumulator FIFO (1) or zero (0) |
| dstAcc | input | 1 | Send the tail sum into the FIFO (1) or to the output (0) |
| sumValid | output | 1 | Output beat qualifier |
| sumOut | output | ACC_W | Weighted sum, signed, 14 fractional bits |

## Verification
The bound checker watches every cycle. It checks that each stage's valid bit reaches the next stage one cycle later, that a stage outside the lane count copies its incoming sum exactly, and that a stage seeing a bubble keeps its sum. It also checks that the accumulator FIFO is never popped while empty or pushed while full. The values of the sums can only be shown by the bench's scenarios. These cover the products of each element's activation and weight, the isolation of weight writes and activation loads, and the order in which partial sums return across three chained passes. The bench compares each sum with an arithmetic model.

// File: rtl/mac_chain_pkg.sv
`timescale 1ns/1ps
package mac_chain_pkg;
  // strobes from the control half to the datapath
  typedef struct packed {
    logic injectValid;
    logic headFromAcc;
    logic accPop;
    logic accPush;
    logic outFire;
  } chainStrobe_t;
endpackage

// File: rtl/mac_stage.sv
`timescale 1ns/1ps
module mac_stage #(
  parameter int IDX = 0,
  parameter int DATA_W = 16,
  parameter int ACC_W = 48,
  parameter int DEPTH = 1024,
  parameter int PE_W = 3,
  parameter int ADDR_W = 10,
  parameter int LANE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wgtWrEn,
  input  logic [PE_W-1:0]   wgtWrPe,
  input  logic [ADDR_W-1:0] wgtWrAddr,
  input  logic [DATA_W-1:0] wgtWrData,
  input  logic              actLoad,
  input  logic [PE_W-1:0]   actPe,
  input  logic [DATA_W-1:0] actData,
  input  logic              inValid,
  input  logic [ACC_W-1:0]  inSum,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [LANE_W-1:0] inLanes,
  input  logic              inDst,
  output logic              outValid,
  output logic [ACC_W-1:0]  outSum,
  output logic [ADDR_W-1:0] outAddr,
  output logic [LANE_W-1:0] outLanes,
  output logic              outDst
);
  localparam int PROD_W = 2 * DATA_W;

  logic [DATA_W-1:0] weightMem [DEPTH];
  logic [DATA_W-1:0] actReg;
  logic signed [PROD_W-1:0] product;
  logic [ACC_W-1:0] addend;
  logic laneActive;

  always_ff @(posedge clk) begin
    if (wgtWrEn && wgtWrPe == PE_W'(IDX)) weightMem[wgtWrAddr] <= wgtWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) actReg <= '0;
    else if (actLoad && actPe == PE_W'(IDX)) actReg <= actData;
  end

  always_comb begin
    laneActive = LANE_W'(IDX) < inLanes;
    product    = $signed(actReg) * $signed(weightMem[inAddr]);
    addend     = laneActive ? ACC_W'(product) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSum   <= '0;
      outAddr  <= '0;
      outLanes <= '0;
      outDst   <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outSum   <= inSum + addend;
        outAddr  <= inAddr;
        outLanes <= inLanes;
        outDst   <= inDst;
      end
    end
  end
endmodule

// File: rtl/acc_fifo.sv
`timescale 1ns/1ps
module acc_fifo #(
  parameter int WIDTH = 48,
  parameter int DEPTH = 1024
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign headData = store[rdPtr];
  assign empty    = count == '0;
  assign full     = count == CNT_W'(DEPTH);

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/chain_ctrl.sv
`timescale 1ns/1ps
module chain_ctrl
  import mac_chain_pkg::*;
(
  input  logic         issue,
  input  logic         srcAcc,
  input  logic         tailValid,
  input  logic         tailDst,
  output chainStrobe_t strobes
);
  always_comb begin
    strobes.injectValid = issue;
    strobes.headFromAcc = issue && srcAcc;
    strobes.accPop      = issue && srcAcc;
    strobes.accPush     = tailValid && tailDst;
    strobes.outFire     = tailValid && !tailDst;
  end
endmodule

// File: rtl/mac_chain.sv
`timescale 1ns/1ps
module mac_chain
  import mac_chain_pkg::*;
#(
  parameter int NUM_PE = 8,
  parameter int DATA_W = 16,
  parameter int ACC_W = 48,
  parameter int WMEM_DEPTH = 1024,
  parameter int ACC_DEPTH = 1024,
  localparam int PE_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1,
  localparam int ADDR_W = (WMEM_DEPTH > 1) ? $clog2(WMEM_DEPTH) : 1,
  localparam int LANE_W = $clog2(NUM_PE + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wgtWrEn,
  input  logic [PE_W-1:0]   wgtWrPe,
  input  logic [ADDR_W-1:0] wgtWrAddr,
  input  logic [DATA_W-1:0] wgtWrData,
  input  logic              actLoad,
  input  logic [PE_W-1:0]   actPe,
  input  logic [DATA_W-1:0] actData,
  input  logic              issue,
  input  logic [ADDR_W-1:0] issueAddr,
  input  logic [LANE_W-1:0] issueLanes,
  input  logic              srcAcc,
  input  logic              dstAcc,
  output logic              sumValid,
  output logic [ACC_W-1:0]  sumOut
);
  chainStrobe_t strobes;
  logic              stageValid [NUM_PE+1];
  logic [ACC_W-1:0]  stageSum   [NUM_PE+1];
  logic [ADDR_W-1:0] stageAddr  [NUM_PE+1];
  logic [LANE_W-1:0] stageLanes [NUM_PE+1];
  logic              stageDst   [NUM_PE+1];
  logic [ACC_W-1:0]  accHead;
  logic              accEmpty, accFull;

  chain_ctrl u_ctrl (
    .issue     (issue),
    .srcAcc    (srcAcc),
    .tailValid (stageValid[NUM_PE]),
    .tailDst   (stageDst[NUM_PE]),
    .strobes   (strobes)
  );

  assign stageValid[0] = strobes.injectValid;
  assign stageSum[0]   = strobes.headFromAcc ? accHead : '0;
  assign stageAddr[0]  = issueAddr;
  assign stageLanes[0] = issueLanes;
  assign stageDst[0]   = dstAcc;

  for (genvar k = 0; k < NUM_PE; k++) begin : g_pe
    mac_stage #(
      .IDX(k), .DATA_W(DATA_W), .ACC_W(ACC_W), .DEPTH(WMEM_DEPTH),
      .PE_W(PE_W), .ADDR_W(ADDR_W), .LANE_W(LANE_W)
    ) u_stage (
      .clk       (clk),
      .rstN      (rstN),
      .wgtWrEn   (wgtWrEn),
      .wgtWrPe   (wgtWrPe),
      .wgtWrAddr (wgtWrAddr),
      .wgtWrData (wgtWrData),
      .actLoad   (actLoad),
      .actPe     (actPe),
      .actData   (actData),
      .inValid   (stageValid[k]),
      .inSum     (stageSum[k]),
      .inAddr    (stageAddr[k]),
      .inLanes   (stageLanes[k]),
      .inDst     (stageDst[k]),
      .outValid  (stageValid[k+1]),
      .outSum    (stageSum[k+1]),
      .outAddr   (stageAddr[k+1]),
      .outLanes  (stageLanes[k+1]),
      .outDst    (stageDst[k+1])
    );
  end

  acc_fifo #(.WIDTH(ACC_W), .DEPTH(ACC_DEPTH)) u_acc (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strobes.accPush),
    .pushData (stageSum[NUM_PE]),
    .pop      (strobes.accPop),
    .headData (accHead),
    .empty    (accEmpty),
    .full     (accFull)
  );

  assign sumValid = strobes.outFire;
  assign sumOut   = stageSum[NUM_PE];
endmodule

// File: rtl/mac_chain_checker.sv
`timescale 1ns/1ps
module mac_chain_checker #(
  parameter int NUM_PE = 8,
  parameter int ACC_W = 48,
  parameter int LANE_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              sumValid,
  input logic              stageValid [NUM_PE+1],
  input logic [ACC_W-1:0]  stageSum   [NUM_PE+1],
  input logic [LANE_W-1:0] stageLanes [NUM_PE+1],
  input logic              accPop,
  input logic              accPush,
  input logic              accEmpty,
  input logic              accFull
);
  // R1: first cycle out of reset shows no output beat
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rstN) |-> !sumValid);

  for (genvar k = 0; k < NUM_PE; k++) begin : g_stage
    // R3: a token advances exactly one stage per cycle
    a_r3_advance: assert property (@(posedge clk) disable iff (!rstN)
      stageValid[k] |=> stageValid[k+1]);
    a_r3_no_phantom: assert property (@(posedge clk) disable iff (!rstN)
      !stageValid[k] |=> !stageValid[k+1]);
    // R4: stage outside the lane count forwards its sum untouched
    a_r4_passthrough: assert property (@(posedge clk) disable iff (!rstN)
      (stageValid[k] && stageLanes[k] <= LANE_W'(k))
      |=> stageSum[k+1] == $past(stageSum[k]));
    // R7: a bubble leaves the stage sum as it was
    a_r7_bubble_hold: assert property (@(posedge clk) disable iff (!rstN)
      !stageValid[k] |=> $stable(stageSum[k+1]));
  end

  // R5: reinjection never reads an empty FIFO
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    accPop |-> !accEmpty);
  // R6: parking a partial sum never overruns the FIFO
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (accPush && !accPop) |-> !accFull);
endmodule

bind mac_chain mac_chain_checker #(
  .NUM_PE(NUM_PE), .ACC_W(ACC_W), .LANE_W(LANE_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sumValid   (sumValid),
  .stageValid (stageValid),
  .stageSum   (stageSum),
  .stageLanes (stageLanes),
  .accPop     (strobes.accPop),
  .accPush    (strobes.accPush),
  .accEmpty   (accEmpty),
  .accFull    (accFull)
);

// File: tb/test_mac_chain.sv
`timescale 1ns/1ps
module test_mac_chain;
  localparam int NP = 4;
  localparam int WD = 16;
  localparam int AD = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wgtWrEn = 0, actLoad = 0, issue = 0, srcAcc = 0, dstAcc = 0;
  logic [1:0] wgtWrPe = 0, actPe = 0;
  logic [3:0] wgtWrAddr = 0, issueAddr = 0;
  logic [15:0] wgtWrData = 0, actData = 0;
  logic [2:0] issueLanes = 0;
  logic sumValid;
  logic [47:0] sumOut;

  mac_chain #(.NUM_PE(NP), .WMEM_DEPTH(WD), .ACC_DEPTH(AD)) i_mac_chain (.*);

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nVec = 0, nFail = 0;
  bit done = 0;

  logic signed [15:0] wModel [NP][WD];
  logic signed [15:0] aModel [NP];
  logic [47:0] accQ [$];
  bit          expV [64];
  logic [47:0] expS [64];
  string       expT [64];

  task automatic checkNow();
    int s = cyc % 64;
    nVec++;
    if (expV[s]) begin
      if (!sumValid || sumOut !== expS[s]) begin
        nFail++;
        $display("FAIL %s cycle %0d: valid=%0b sum=%h expected valid=1 sum=%h",
                 expT[s], cyc, sumValid, sumOut, expS[s]);
      end
    end else if (sumValid !== 1'b0) begin
      nFail++;
      $display("FAIL R7/R6 cycle %0d: valid=%0b expected valid=0", cyc, sumValid);
    end
    expV[s] = 0;
  endtask

  task automatic quiet();
    wgtWrEn = 0; actLoad = 0; issue = 0; srcAcc = 0; dstAcc = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); checkNow(); quiet();
    end
  endtask

  task automatic writeW(input int pe, input int addr, input logic [15:0] d);
    @(negedge clk); checkNow(); quiet();
    wgtWrEn = 1; wgtWrPe = 2'(pe); wgtWrAddr = 4'(addr); wgtWrData = d;
    wModel[pe][addr] = d;
  endtask

  task automatic loadA(input int pe, input logic [15:0] d);
    @(negedge clk); checkNow(); quiet();
    actLoad = 1; actPe = 2'(pe); actData = d;
    aModel[pe] = d;
  endtask

  task automatic fire(input int addr, input int lanes, input bit sa, input bit da,
                      input string tag);
    logic [47:0] acc;
    int s;
    @(negedge clk); checkNow(); quiet();
    issue = 1; issueAddr = 4'(addr); issueLanes = 3'(lanes); srcAcc = sa; dstAcc = da;
    acc = sa ? accQ.pop_front() : 48'd0;
    for (int i = 0; i < lanes; i++)
      acc = acc + 48'(longint'(aModel[i]) * longint'(wModel[i][addr]));
    if (da) accQ.push_back(acc);
    else begin
      s = (cyc + NP) % 64;
      expV[s] = 1; expS[s] = acc; expT[s] = tag;
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) expV[i] = 0;
    for (int p = 0; p < NP; p++) aModel[p] = 0;
    // R1: output quiet while reset is held
    repeat (3) begin
      @(negedge clk);
      nVec++;
      if (sumValid !== 1'b0) begin
        nFail++;
        $display("FAIL R1 reset: valid=%0b expected 0", sumValid);
      end
    end
    rstN = 1;
    for (int p = 0; p < NP; p++)
      for (int a = 0; a < WD; a++)
        writeW(p, a, 16'(p * 12345 + a * 2741 + 77));
    // R1: activations cleared by reset, sum is head value (zero)
    fire(5, NP, 0, 0, "R1");
    idle(NP);
    for (int p = 0; p < NP; p++) loadA(p, 16'(p * 9001 - 3000));
    // R2/R3: full-lane sweep over all addresses, back to back
    for (int a = 0; a < WD; a++) fire(a, NP, 0, 0, "R2/R3");
    // R4: every lane count, one per cycle
    for (int l = 0; l <= NP; l++) fire(l + 3, l, 0, 0, "R4");
    // R7: bubbles interleaved
    for (int a = 0; a < 6; a++) begin fire(a, NP, 0, 0, "R7"); idle(a % 3); end
    idle(NP + 1);
    // R8: one weight entry rewritten, neighbours unaffected
    writeW(2, 3, 16'h8001);
    for (int a = 2; a < 5; a++) fire(a, NP, 0, 0, "R8");
    // R9: one activation replaced
    loadA(1, 16'h7fff);
    idle(1);
    fire(3, NP, 0, 0, "R9");
    fire(9, 2, 0, 0, "R9");
    idle(NP + 1);
    // R2 extremes: most negative operands everywhere
    for (int p = 0; p < NP; p++) begin writeW(p, 15, 16'h8000); loadA(p, 16'h8000); end
    idle(1);
    fire(15, NP, 0, 0, "R2");
    idle(NP + 1);
    // R5/R6: three chained passes through the accumulator FIFO
    for (int p = 0; p < NP; p++) loadA(p, 16'(p * 311 + 5));
    idle(1);
    for (int a = 0; a < 8; a++) fire(a, NP, 0, 1, "R6");
    idle(NP + 1);
    for (int p = 0; p < NP; p++) loadA(p, 16'(-p * 1207 - 9));
    idle(1);
    for (int a = 8; a < 16; a++) fire(a, NP, 1, 1, "R6");
    idle(NP + 1);
    for (int p = 0; p < NP; p++) loadA(p, 16'(p * 4000 + 123));
    idle(1);
    for (int a = 0; a < 8; a++) fire(a, a % (NP + 1), 1, 0, "R5");
    idle(NP + 3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end
endmodule